// File: doc/BRIEF.md
# Taskfile Register List Sequencer

This block sits between a descriptor byte stream and the 8-bit register port of a disk taskfile. A descriptor arrives one byte per handshake, starting at its first byte. The first sixteen bytes are a header. One header byte gives the descriptor length. From byte 16 on, the descriptor holds a list of two-byte entries. Each entry carries a data value and then an address byte with two flags in it. The sequencer decodes each entry and performs the register writes in list order. It then reports completion, or reports an error when the list runs past the declared length.

A write is presented on `wr_en`/`wr_addr`/`wr_data` and held until the port accepts it with `wr_ready`. The input stream is stalled while a write is pending. When a descriptor finishes, normally or with an error, the next accepted byte is taken as byte 0 of a new descriptor. This lets back-to-back commands, including 48-bit commands that write the same register twice, pass through without any software involvement.

Top module: `tf_reglist_seq`

## Requirements
- R1: During reset `in_ready`, `wr_en`, `done` and `err` are low. After reset, `in_ready` is high exactly when no register write is pending. A byte is consumed on a cycle with `in_valid` and `in_ready` both high. After a write completes, `wr_en` is low in the following cycle.
- R2: Descriptor bytes 0 to 15 form a header, and byte 3 holds a length L. The descriptor spans (L+2)*8 bytes. No header byte causes a write, even when its bits 5 or 7 are set.
- R3: From byte 16 on, even-indexed bytes are data values and odd-indexed bytes are address bytes. Accepting an address byte asserts `wr_en` in the next cycle, with `wr_data` equal to the preceding value byte and `wr_addr` equal to bits 4:0 of the address byte.
- R4: An address byte with bit 5 set causes no write for its entry.
- R5: An address byte with bit 7 set ends the list. `done` pulses for one cycle. If the entry writes, the pulse comes in the cycle after that write's handshake. If the entry is skipped, it comes in the cycle after the address byte is accepted.
- R6: While `wr_en` is high and `wr_ready` is low, `wr_en`, `wr_addr` and `wr_data` hold their values.
- R7: Writes leave in list order, and every entry is written even when an earlier entry used the same register address. A 48-bit command therefore writes its high-order bytes first and then its low-order bytes to the same registers.
- R8: If byte (L+2)*8-1 is accepted and it is not an end-marked address byte, `err` pulses for one cycle in the following cycle. The write for that entry is still issued unless it is skipped. `done` is not raised, and the next byte starts a new descriptor.
- R9: `done` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Descriptor byte available |
| in_ready | output | 1 | Sequencer can take a byte |
| in_data | input | 8 | Descriptor byte |
| wr_ready | input | 1 | Register port accepts the pending write |
| wr_en | output | 1 | Register write pending |
| wr_addr | output | 5 | Taskfile register address |
| wr_data | output | 8 | Value to write |
| done | output | 1 | One-cycle pulse: list ended at an end-marked entry |
| err | output | 1 | One-cycle pulse: length limit reached without an end mark |

## Verification
The properties assume two things about the producer. It holds `in_valid` and `in_data` until a byte is taken, and it starts each stream on a descriptor boundary. The register port may stall for any number of cycles. The directed stimulus changes inputs only between clock edges. It presents every descriptor from byte 0, and it stalls `wr_ready` on a fixed pattern in one scenario to exercise holding. The lengths it declares either match the list or are deliberately short, which drives the limit path.

// File: rtl/tf_seq_pkg.sv
package tf_seq_pkg;
  // flag bit positions inside an entry's address byte
  localparam int unsigned TF_SKIP_BIT  = 5;
  localparam int unsigned TF_LAST_BIT  = 7;
  // width of the register address passed to the port
  localparam int unsigned TF_RADDR_W   = 5;
  // header layout
  localparam int unsigned TF_LEN_IDX   = 3;
  localparam int unsigned TF_LIST_OFS  = 16;
  localparam int unsigned TF_UNIT_LOG2 = 3;

  typedef struct packed {
    logic                  skip;
    logic                  last;
    logic [TF_RADDR_W-1:0] raddr;
  } tf_ent_t;
endpackage

// File: rtl/tf_entry_dec.sv
module tf_entry_dec
  import tf_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] abyte,
  output tf_ent_t           ent
);
  always_comb begin
    ent.skip  = abyte[TF_SKIP_BIT];
    ent.last  = abyte[TF_LAST_BIT];
    ent.raddr = abyte[TF_RADDR_W-1:0];
  end
endmodule

// File: rtl/tf_hdr_track.sv
module tf_hdr_track
  import tf_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              acc,
  input  logic              restart,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_list,
  output logic              idx_odd,
  output logic              at_limit
);
  localparam int unsigned CNT_W = LEN_W + TF_UNIT_LOG2 + 1;

  logic [CNT_W-1:0] idx_q, idx_d, lim_last;
  logic [LEN_W-1:0] len_q, len_d;
  logic             len_en;

  always_comb begin
    idx_d    = restart ? '0 : idx_q + CNT_W'(1);
    len_en   = acc && (idx_q == CNT_W'(TF_LEN_IDX));
    len_d    = in_data[LEN_W-1:0];
    lim_last = (CNT_W'(len_q) << TF_UNIT_LOG2) + CNT_W'(TF_LIST_OFS - 1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      idx_q <= '0;
      len_q <= '0;
    end else begin
      if (acc)    idx_q <= idx_d;
      if (len_en) len_q <= len_d;
    end
  end

  assign in_list  = (idx_q >= CNT_W'(TF_LIST_OFS));
  assign idx_odd  = idx_q[0];
  assign at_limit = (idx_q == lim_last);
endmodule

// File: rtl/tf_wr_stage.sv
module tf_wr_stage
  import tf_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  load,
  input  tf_ent_t               ld_ent,
  input  logic [DATA_W-1:0]     ld_data,
  input  logic                  wr_ready,
  output logic                  wr_en,
  output logic [TF_RADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  fire,
  output logic                  last_out
);
  logic                  pend_q, pend_d;
  logic [TF_RADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     data_q;
  logic                  last_q;

  always_comb begin
    fire   = pend_q && wr_ready;
    pend_d = pend_q;
    if (fire) pend_d = 1'b0;
    if (load) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (load) begin
        addr_q <= ld_ent.raddr;
        data_q <= ld_data;
        last_q <= ld_ent.last;
      end
    end
  end

  assign wr_en    = pend_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign last_out = last_q;
endmodule

// File: rtl/tf_reglist_seq.sv
module tf_reglist_seq
  import tf_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  wr_ready,
  output logic                  wr_en,
  output logic [TF_RADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  done,
  output logic                  err
);
  logic [1:0]        rsync_q;
  logic              arst_n;
  logic              acc, in_list, idx_odd, at_limit;
  logic              is_adr, end_hit, lim_hit, restart, load;
  logic              fire, last_q;
  logic              val_en;
  logic [DATA_W-1:0] val_q;
  logic              done_d, err_d, done_q, err_q;
  tf_ent_t           ent;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  tf_hdr_track #(.DATA_W(DATA_W), .LEN_W(LEN_W)) hdr_i (
    .clk(clk), .arst_n(arst_n), .acc(acc), .restart(restart),
    .in_data(in_data), .in_list(in_list), .idx_odd(idx_odd), .at_limit(at_limit)
  );

  tf_entry_dec #(.DATA_W(DATA_W)) dec_i (.abyte(in_data), .ent(ent));

  tf_wr_stage #(.DATA_W(DATA_W)) wr_i (
    .clk(clk), .arst_n(arst_n), .load(load), .ld_ent(ent), .ld_data(val_q),
    .wr_ready(wr_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fire(fire), .last_out(last_q)
  );

  always_comb begin
    in_ready = arst_n && !wr_en;
    acc      = in_valid && in_ready;
    is_adr   = in_list && idx_odd;
    val_en   = acc && in_list && !idx_odd;
    end_hit  = acc && is_adr && ent.last;
    lim_hit  = acc && at_limit && !(is_adr && ent.last);
    restart  = end_hit || lim_hit;
    load     = acc && is_adr && !ent.skip;
    done_d   = (end_hit && ent.skip) || (fire && last_q);
    err_d    = lim_hit;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      val_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (val_en) val_q <= in_data;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/tf_reglist_seq_chk.sv
module tf_reglist_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wr_ready,
  input logic              wr_en,
  input logic [4:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done,
  input logic              err
);
  // R6
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_ready |=> wr_en && $stable(wr_addr) && $stable(wr_data));

  // R1
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ready |=> !wr_en);

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_ready) || $past(in_valid && in_ready));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready));
endmodule

bind tf_reglist_seq tf_reglist_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_ready(wr_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .err(err)
);

// File: tb/tf_reglist_seq_tb_top.sv
`timescale 1ns/1ps
module tf_reglist_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       wr_ready;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic       done;
  logic       err;

  int n_chk = 0;
  int n_bad = 0;
  int ncyc  = 0;
  bit stall_en = 0;
  bit mon_on = 0;

  logic [7:0] desc [0:63];
  int nb;
  int acc_cyc [0:63];

  int got_n, done_n, err_n, both_n, ovl_n, done_cyc, err_cyc;
  int got_a [0:63];
  int got_d [0:63];
  int got_c [0:63];
  int exp_n;
  int exp_a [0:63];
  int exp_d [0:63];

  tf_reglist_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_ready(wr_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) ncyc <= ncyc + 1;
  assign wr_ready = !stall_en || (ncyc % 3 == 0);

  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_en && wr_ready) begin
        got_a[got_n] = int'(wr_addr);
        got_d[got_n] = int'(wr_data);
        got_c[got_n] = ncyc;
        got_n++;
      end
      if (done) begin done_n++; done_cyc = ncyc; end
      if (err) begin err_n++; err_cyc = ncyc; end
      if (done && err) both_n++;
      if (wr_en && in_ready) ovl_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_hdr(input logic [7:0] len);
    for (int i = 0; i < 16; i++) desc[i] = 8'hA0 | 8'(i);
    desc[3] = len;
    nb = 16;
  endtask

  task automatic put_ent(input logic [7:0] v, input logic [7:0] a);
    desc[nb] = v;
    desc[nb+1] = a;
    nb += 2;
  endtask

  task automatic run_desc(input string req, input bit stall);
    int lim;
    stall_en = stall;
    got_n = 0; done_n = 0; err_n = 0; both_n = 0; ovl_n = 0;
    done_cyc = -1; err_cyc = -1;
    mon_on = 1;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = desc[i];
      while (!in_ready) @(negedge clk);
      acc_cyc[i] = ncyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    mon_on = 0;
    stall_en = 0;
    // expected writes from the list rules
    lim = (int'(desc[3]) + 2) * 8;
    exp_n = 0;
    for (int i = 16; i + 1 < nb && i + 1 < lim; i += 2) begin
      if (desc[i+1][5] == 1'b0) begin
        exp_a[exp_n] = int'(desc[i+1][4:0]);
        exp_d[exp_n] = int'(desc[i]);
        exp_n++;
      end
      if (desc[i+1][7]) break;
    end
    chk(got_n == exp_n, req, "write count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(got_a[k] == exp_a[k] && got_d[k] == exp_d[k], req, "write addr/data",
          (got_a[k] << 8) | got_d[k], (exp_a[k] << 8) | exp_d[k]);
    end
    chk(both_n == 0, "R9", "done with err", both_n, 0);
    chk(ovl_n == 0, "R1", "in_ready while write pending", ovl_n, 0);
  endtask

  task automatic build_lba28();
    put_hdr(8'd2);
    put_ent(8'hE0, 8'h16);
    put_ent(8'h08, 8'h12);
    put_ent(8'h11, 8'h13);
    put_ent(8'h22, 8'h14);
    put_ent(8'h33, 8'h15);
    put_ent(8'h00, 8'h0E);
    put_ent(8'h00, 8'h20);
    put_ent(8'hC8, 8'h97);
  endtask

  task automatic t_reset();
    in_valid = 1'b0;
    in_data  = 8'h00;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !wr_en && !done && !err, "R1", "outputs in reset",
        {in_ready, wr_en, done, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready && !wr_en && !done && !err, "R1", "outputs after reset",
        {in_ready, wr_en, done, err}, 4'b1000);
  endtask

  task automatic t_lba28();
    build_lba28();
    run_desc("R2/R3/R4", 1'b0);
    chk(done_n == 1 && err_n == 0, "R5", "done/err count", (done_n << 4) | err_n, 16);
    chk(got_n > 0 && got_c[0] == acc_cyc[17] + 1, "R3", "first write cycle",
        got_c[0], acc_cyc[17] + 1);
    chk(got_n > 0 && done_cyc == got_c[got_n-1] + 1, "R5", "done after last write",
        done_cyc, got_c[got_n-1] + 1);
  endtask

  task automatic t_lba48();
    put_hdr(8'd3);
    put_ent(8'h40, 8'h16);
    put_ent(8'h01, 8'h12);
    put_ent(8'h44, 8'h13);
    put_ent(8'h55, 8'h14);
    put_ent(8'h66, 8'h15);
    put_ent(8'h02, 8'h12);
    put_ent(8'h77, 8'h13);
    put_ent(8'h88, 8'h14);
    put_ent(8'h99, 8'h15);
    put_ent(8'h00, 8'h0E);
    put_ent(8'h00, 8'h20);
    put_ent(8'h25, 8'h97);
    run_desc("R7", 1'b0);
    chk(done_n == 1 && err_n == 0, "R7", "done/err count", (done_n << 4) | err_n, 16);
  endtask

  task automatic t_stall();
    build_lba28();
    run_desc("R6", 1'b1);
    chk(done_n == 1 && err_n == 0, "R6", "done/err count under stall",
        (done_n << 4) | err_n, 16);
  endtask

  task automatic t_end_skip();
    put_hdr(8'd1);
    put_ent(8'h5A, 8'h12);
    put_ent(8'h11, 8'h0E);
    put_ent(8'h3C, 8'h17);
    put_ent(8'hFF, 8'hA0);
    run_desc("R4/R5", 1'b0);
    chk(done_n == 1 && err_n == 0, "R5", "done/err count skip end", (done_n << 4) | err_n, 16);
    chk(done_cyc == acc_cyc[23] + 1, "R5", "done after skipped end", done_cyc, acc_cyc[23] + 1);
  endtask

  task automatic t_limit_empty();
    put_hdr(8'd0);
    run_desc("R8", 1'b0);
    chk(err_n == 1 && done_n == 0, "R8", "err on empty list", (err_n << 4) | done_n, 16);
    chk(err_cyc == acc_cyc[15] + 1, "R8", "err cycle empty", err_cyc, acc_cyc[15] + 1);
  endtask

  task automatic t_limit_run();
    put_hdr(8'd1);
    put_ent(8'h01, 8'h12);
    put_ent(8'h02, 8'h13);
    put_ent(8'h03, 8'h14);
    put_ent(8'h04, 8'h15);
    run_desc("R8", 1'b0);
    chk(err_n == 1 && done_n == 0, "R8", "err on unterminated list", (err_n << 4) | done_n, 16);
    chk(err_cyc == acc_cyc[23] + 1, "R8", "err cycle", err_cyc, acc_cyc[23] + 1);
  endtask

  initial begin
    t_reset();
    t_lba28();
    t_lba48();
    t_stall();
    t_end_skip();
    t_limit_empty();
    t_limit_run();
    // R8: next descriptor after an error starts clean
    t_lba28();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule